// File: doc/BRIEF.md
# Four-Mode 16-Bit Down Timer

This block is a 16-bit down-counter with a 16-bit reload latch. An 8-bit mode register selects its function. There are four functions: an interval timer, a square-wave generator on the CNTR output, an edge counter on the CNTR input, and a level-gated timer that measures pulse width on the CNTR input. In the interval and pulse-width functions the count source is either a free-running prescaler or an external one-cycle strobe from a special count-source generator. The prescaler divides the clock by 8, 16, 32 or 64.

Software talks to the block through byte-wide register accesses. Writes use `wr_en`, `wr_addr` and `wr_data`. Reads are combinational through `rd_addr` and `rd_data`. There are four addresses:

- 0 is the counter low byte.
- 1 is the counter high byte.
- 2 is the mode register.
- 3 is the status register.

When the counter decrements from zero, that is an underflow. On underflow the counter reloads from the latch and raises a sticky request flag. A second sticky flag records CNTR edges. One polarity bit in the mode register sets the start level of the output wave, the counted edge, the gating level and the edge that raises a request, in every function at once.

The run control is a two-state machine. `S_HALT` holds the counter and the latch unchanged. `S_COUNT` decrements on each qualified tick. The transition GO (`S_HALT` to `S_COUNT`) and the transition PAUSE (`S_COUNT` to `S_HALT`) take effect on the same clock edge that writes the stop bit.

Top module: `mt16_timer`

## Requirements
- R1: After reset the counter and latch hold 0xFFFF. The mode register reads 0x80 (stopped). The status register reads 0. `cntr_oe`, `irq_uflow` and `irq_edge` are 0, and `cntr_out` is 1.
- R2: The mode byte is {stop[7], latch_only[6], src[5:3], pol[2], func[1:0]}. The func codes are 00 interval, 01 wave output, 10 edge count and 11 width measure. When src[5]=1 the count source is `src_strobe`. On each tick the counter decrements by one. A tick taken at count 0 is an underflow: the counter loads the latch value.
- R3: The src codes 000, 001, 010 and 011 select one tick every 8, 16, 32 and 64 clocks from a free-running prescaler.
- R4: While the stop bit is 1 (state `S_HALT`), ticks and edges do not change the counter. Stop bit changes take effect on the edge that writes them.
- R5: Every underflow sets status bit 0 and `irq_uflow`. Writing 0 to status bit 0 clears it. Writing 1 to it has no effect.
- R6: With latch_only=0, a write to address 0 or 1 loads that byte into both the counter and the latch. A write in the same cycle as a tick overrides the decremented value for that byte.
- R7: With latch_only=1, a timer-byte write changes only the latch, and the counter takes the latch at its next underflow. A high-byte write in the same cycle as an underflow is included in that reload.
- R8: In wave-output mode `cntr_oe` is 1. A mode write sets `cntr_out` to the inverse of the new pol. Each underflow toggles `cntr_out`, and nothing else changes it.
- R9: In edge-count mode, after a 2-flop synchroniser, each rising CNTR edge (pol=0) or each falling CNTR edge (pol=1) is one tick.
- R10: In width-measure mode, source ticks count only while the synchronised CNTR is high (pol=0) or low (pol=1).
- R11: In all modes, the edge selected by pol sets status bit 1 and `irq_edge`. Writing 0 to status bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 low, 1 high, 2 mode, 3 status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| src_strobe | input | 1 | One-cycle external count-source strobe |
| cntr_in | input | 1 | CNTR pin input (asynchronous) |
| cntr_out | output | 1 | CNTR pin output level |
| cntr_oe | output | 1 | CNTR output enable |
| irq_uflow | output | 1 | Sticky underflow request |
| irq_edge | output | 1 | Sticky CNTR edge request |

## Verification
Errors in the run state or the latch show up at the counter bytes within one tick. A missed halt shifts the count at once. A wrong latch value appears at the first underflow as a wrong reload value, together with `irq_uflow`. A wrong output-level register is visible on `cntr_out` at the next underflow or mode write. A fault in the synchroniser or the edge selection shows up three clocks after a CNTR transition, as a missing decrement or a wrong `irq_edge`.

// File: rtl/mt16_pkg.sv
package mt16_pkg;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

    typedef enum logic [1:0] {
        MD_TIMER = 2'b00,
        MD_PULSE = 2'b01,
        MD_EVENT = 2'b10,
        MD_WIDTH = 2'b11
    } tmode_e;

    typedef enum logic {
        S_HALT  = 1'b0,
        S_COUNT = 1'b1
    } run_state_e;

    typedef struct packed {
        logic       stop;
        logic       latch_only;
        logic [2:0] src;
        logic       pol;
        tmode_e     func;
    } mode_reg_t;

    localparam logic [7:0] MODE_RESET = 8'h80;

endpackage

// File: rtl/mt16_prescale.sv
module mt16_prescale #(
    parameter  int BASE_LOG2 = 3,
    parameter  int NUM_TAPS  = 4,
    localparam int PRE_W     = BASE_LOG2 + NUM_TAPS - 1,
    localparam int SEL_W     = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] taps;

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
    end

    // Tap g fires once every 2**(BASE_LOG2+g) clocks.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign taps[g] = &pre_q[BASE_LOG2+g-1:0];
    end

    assign tick = taps[sel];

endmodule

// File: rtl/mt16_pin_sync.sv
module mt16_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;

endmodule

// File: rtl/mt16_counter.sv
module mt16_counter
    import mt16_pkg::*;
#(
    parameter  int W  = 16,
    parameter  int BW = 8,
    localparam int NB = W / BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_next,
    input  logic          latch_only,
    input  logic          cnt_en,
    input  logic [NB-1:0] wr_sel,
    input  logic [BW-1:0] wr_byte,
    output logic [W-1:0]  count,
    output logic          uflow,
    output run_state_e    state
);

    run_state_e   state_q, state_d;
    logic [W-1:0] count_q, count_d;
    logic [W-1:0] latch_q, latch_d;
    logic         step;

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HALT;
            count_q <= '1;
            latch_q <= '1;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            latch_q <= latch_d;
        end
    end

    // Next-state and output process.
    always_comb begin
        latch_d = latch_q;
        for (int b = 0; b < NB; b++) begin
            if (wr_sel[b]) latch_d[b*BW +: BW] = wr_byte;
        end

        state_d = state_q;
        step    = 1'b0;
        count_d = count_q;
        unique case (state_q)
            S_HALT: begin
                if (run_next) state_d = S_COUNT;   // GO
            end
            S_COUNT: begin
                if (!run_next) state_d = S_HALT;   // PAUSE
                step = cnt_en;
            end
        endcase

        uflow = step && (count_q == '0);
        if (step) begin
            // Reload sees this cycle's latch writes.
            count_d = uflow ? latch_d : (count_q - {{(W-1){1'b0}}, 1'b1});
        end

        if (!latch_only) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_sel[b]) count_d[b*BW +: BW] = wr_byte;
            end
        end
    end

    assign count = count_q;
    assign state = state_q;

endmodule

// File: rtl/mt16_timer.sv
module mt16_timer
    import mt16_pkg::*;
#(
    parameter  int CNT_W     = 16,
    parameter  int BYTE_W    = 8,
    parameter  int SYNC_DEPTH = 2,
    parameter  int PRE_BASE  = 3,
    parameter  int PRE_TAPS  = 4,
    localparam int NBYTES    = CNT_W / BYTE_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        src_strobe,
    input  logic        cntr_in,
    output logic        cntr_out,
    output logic        cntr_oe,
    output logic        irq_uflow,
    output logic        irq_edge
);

    mode_reg_t          mode_q, mode_d;
    logic               uf_q, uf_d;
    logic               edge_q, edge_d;
    logic               out_q, out_d;
    logic               mode_wr, stat_wr;
    logic [NBYTES-1:0]  wr_sel;
    logic               pre_tick, src_tick, cnt_en;
    logic               pin_level, pin_rise, pin_fall, sel_edge;
    logic [CNT_W-1:0]   cnt_val;
    logic               uflow;
    run_state_e         run_state;

    assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
    assign stat_wr = wr_en && (wr_addr == ADDR_STAT);

    for (genvar b = 0; b < NBYTES; b++) begin : g_wsel
        assign wr_sel[b] = wr_en && (wr_addr == 2'(b));
    end

    mt16_prescale #(
        .BASE_LOG2 (PRE_BASE),
        .NUM_TAPS  (PRE_TAPS)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (mode_q.src[1:0]),
        .tick  (pre_tick)
    );

    mt16_pin_sync #(
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cntr_in),
        .level (pin_level),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign src_tick = mode_q.src[2] ? src_strobe : pre_tick;
    assign sel_edge = mode_q.pol ? pin_fall : pin_rise;

    always_comb begin
        unique case (mode_q.func)
            MD_TIMER, MD_PULSE: cnt_en = src_tick;
            MD_EVENT:           cnt_en = sel_edge;
            MD_WIDTH:           cnt_en = src_tick && (pin_level != mode_q.pol);
        endcase
    end

    assign mode_d = mode_wr ? mode_reg_t'(wr_data) : mode_q;

    mt16_counter #(
        .W  (CNT_W),
        .BW (BYTE_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_next   (!mode_d.stop),
        .latch_only (mode_q.latch_only),
        .cnt_en     (cnt_en),
        .wr_sel     (wr_sel),
        .wr_byte    (wr_data[BYTE_W-1:0]),
        .count      (cnt_val),
        .uflow      (uflow),
        .state      (run_state)
    );

    always_comb begin
        uf_d   = uf_q;
        edge_d = edge_q;
        if (stat_wr && !wr_data[0]) uf_d   = 1'b0;
        if (stat_wr && !wr_data[1]) edge_d = 1'b0;
        if (uflow)    uf_d   = 1'b1;
        if (sel_edge) edge_d = 1'b1;

        out_d = out_q;
        if (mode_wr)
            out_d = ~mode_d.pol;
        else if (uflow && mode_q.func == MD_PULSE)
            out_d = ~out_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_reg_t'(MODE_RESET);
            uf_q   <= 1'b0;
            edge_q <= 1'b0;
            out_q  <= 1'b1;
        end else begin
            mode_q <= mode_d;
            uf_q   <= uf_d;
            edge_q <= edge_d;
            out_q  <= out_d;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_LO:   rd_data = cnt_val[7:0];
            ADDR_HI:   rd_data = cnt_val[15:8];
            ADDR_MODE: rd_data = mode_q;
            ADDR_STAT: rd_data = {6'b0, edge_q, uf_q};
        endcase
    end

    assign cntr_out  = out_q;
    assign cntr_oe   = (mode_q.func == MD_PULSE);
    assign irq_uflow = uf_q;
    assign irq_edge  = edge_q;

endmodule

// File: rtl/mt16_checker.sv
module mt16_checker
    import mt16_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [7:0]  wr_data,
    input run_state_e  state,
    input logic [15:0] count,
    input logic        uflow,
    input mode_reg_t   mode,
    input logic        cntr_out,
    input logic        irq_uflow,
    input logic        irq_edge
);

    logic tmr_wr, mode_wr;
    assign tmr_wr  = wr_en && (wr_addr == ADDR_LO || wr_addr == ADDR_HI);
    assign mode_wr = wr_en && (wr_addr == ADDR_MODE);

    assert_halt_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT && !tmr_wr) |=> $stable(count));

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_wr && !uflow) |=> (count == $past(count) || count == $past(count) - 16'd1));

    assert_uflow_sets_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> irq_uflow);

    assert_wave_toggles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.func == MD_PULSE && uflow && !mode_wr) |=> (cntr_out != $past(cntr_out)));

    assert_wave_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!uflow && !mode_wr) |=> $stable(cntr_out));

    assert_edge_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_edge && !(wr_en && wr_addr == ADDR_STAT && !wr_data[1])) |=> irq_edge);

endmodule

bind mt16_timer mt16_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .state     (run_state),
    .count     (cnt_val),
    .uflow     (uflow),
    .mode      (mode_q),
    .cntr_out  (cntr_out),
    .irq_uflow (irq_uflow),
    .irq_edge  (irq_edge)
);

// File: tb/mt16_timer_test.sv
`timescale 1ns/1ps
module mt16_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       src_strobe = 1'b0;
    logic       cntr_in = 1'b0;
    logic       cntr_out, cntr_oe, irq_uflow, irq_edge;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mt16_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_strobe(src_strobe), .cntr_in(cntr_in), .cntr_out(cntr_out),
        .cntr_oe(cntr_oe), .irq_uflow(irq_uflow), .irq_edge(irq_edge)
    );

    // {mode, load, strobes, expected count, expected underflow flag}
    localparam logic [48:0] VEC [8] = '{
        {8'h20, 16'h0005, 8'd3, 16'h0002, 1'b0},
        {8'h20, 16'h0005, 8'd5, 16'h0000, 1'b0},
        {8'h20, 16'h0005, 8'd6, 16'h0005, 1'b1},
        {8'h21, 16'h0000, 8'd1, 16'h0000, 1'b1},
        {8'h20, 16'h0100, 8'd2, 16'h00FE, 1'b0},
        {8'h21, 16'h0003, 8'd9, 16'h0002, 1'b1},
        {8'h23, 16'h0008, 8'd4, 16'h0008, 1'b0},
        {8'h27, 16'h0008, 8'd4, 16'h0004, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            src_strobe = 1'b1;
            @(negedge clk);
            src_strobe = 1'b0;
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic rd_count(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [7:0] stop_mode, input logic [15:0] val);
        wr(2'd2, stop_mode);
        wr(2'd0, val[7:0]);
        wr(2'd1, val[15:8]);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [15:0] c;
        logic [7:0]  v;

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd_count(c);    check("R1 count", c, 16'hFFFF);
        rd(2'd2, v);    check("R1 mode", v, 8'h80);
        rd(2'd3, v);    check("R1 status", v, 8'h00);
        check("R1 pins", {cntr_oe, cntr_out, irq_uflow, irq_edge}, 4'b0100);

        // Vector table: R2 counting and reload, R10 gating
        for (int k = 0; k < 8; k++) begin
            logic [7:0]  vm;
            logic [15:0] vl, ve;
            logic [7:0]  vn;
            logic        vu;
            {vm, vl, vn, ve, vu} = VEC[k];
            load(vm | 8'h80, vl);
            wr(2'd3, 8'h00);
            wr(2'd2, vm);
            strobe(int'(vn));
            rd_count(c);
            check($sformatf("R2 vec%0d count", k), c, ve);
            check($sformatf("R5 vec%0d flag", k), irq_uflow, vu);
        end

        // R4 stop holds count
        load(8'hA0, 16'h0007);
        strobe(3);
        rd_count(c);    check("R4 halted count", c, 16'h0007);

        // R5 write 1 ignored, write 0 clears
        wr(2'd2, 8'h20);
        strobe(8);      // 7..0 then underflow
        check("R5 set", irq_uflow, 1'b1);
        wr(2'd3, 8'hFF);
        check("R5 write one keeps", irq_uflow, 1'b1);
        wr(2'd3, 8'h02);
        check("R5 clear", irq_uflow, 1'b0);

        // R6 direct write wins over same-cycle tick
        load(8'hA0, 16'h0410);
        wr(2'd2, 8'h20);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h33; src_strobe = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; src_strobe = 1'b0;
        rd_count(c);    check("R6 write priority", c, 16'h0433);

        // R7 latch-only write, deferred reload
        load(8'hA0, 16'h0002);
        wr(2'd2, 8'h60);
        wr(2'd0, 8'h05);
        rd_count(c);    check("R7 counter untouched", c, 16'h0002);
        strobe(2);
        rd_count(c);    check("R7 before reload", c, 16'h0000);
        strobe(1);
        rd_count(c);    check("R7 deferred reload", c, 16'h0005);

        // R7 high-byte write coincident with underflow
        load(8'hA0, 16'h0000);
        wr(2'd2, 8'h60);
        wr(2'd3, 8'h00);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h12; src_strobe = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; src_strobe = 1'b0;
        rd_count(c);    check("R7 coincident reload", c, 16'h1200);
        check("R7 coincident flag", irq_uflow, 1'b1);

        // R8 wave output
        load(8'hA1, 16'h0001);
        check("R8 oe", cntr_oe, 1'b1);
        check("R8 start high", cntr_out, 1'b1);
        wr(2'd2, 8'h21);
        strobe(1);
        check("R8 no toggle without underflow", cntr_out, 1'b1);
        strobe(1);
        check("R8 toggle on underflow", cntr_out, 1'b0);
        strobe(2);
        check("R8 second toggle", cntr_out, 1'b1);
        wr(2'd2, 8'h25);
        check("R8 start low pol1", cntr_out, 1'b0);

        // R3 prescaler div8 and div64
        load(8'h80, 16'h0100);
        wr(2'd2, 8'h00);
        wait_cyc(63);
        wr(2'd2, 8'h80);
        rd_count(c);    check("R3 div8", c, 16'h00F8);
        load(8'h98, 16'h0100);
        wr(2'd2, 8'h18);
        wait_cyc(127);
        wr(2'd2, 8'h98);
        rd_count(c);    check("R3 div64", c, 16'h00FE);

        // R9 / R11 edge counting
        load(8'hA2, 16'h000A);
        wr(2'd2, 8'h02);
        wr(2'd3, 8'h00);
        for (int p = 0; p < 3; p++) begin
            cntr_in = 1'b1; wait_cyc(5);
            cntr_in = 1'b0; wait_cyc(5);
        end
        rd_count(c);    check("R9 rising edges", c, 16'h0007);
        check("R11 edge set", irq_edge, 1'b1);
        wr(2'd3, 8'h01);
        check("R11 edge clear", irq_edge, 1'b0);
        wr(2'd2, 8'h06);
        cntr_in = 1'b1; wait_cyc(5);
        check("R11 rise ignored pol1", irq_edge, 1'b0);
        rd_count(c);    check("R9 rise ignored pol1", c, 16'h0007);
        cntr_in = 1'b0; wait_cyc(5);
        check("R11 fall sets pol1", irq_edge, 1'b1);
        rd_count(c);    check("R9 falling edge", c, 16'h0006);

        // R10 width measure, level high with pol0
        load(8'hA3, 16'h0014);
        cntr_in = 1'b1; wait_cyc(4);
        wr(2'd2, 8'h23);
        strobe(4);
        rd_count(c);    check("R10 counts while high", c, 16'h0010);
        cntr_in = 1'b0; wait_cyc(4);
        strobe(3);
        rd_count(c);    check("R10 gated while low", c, 16'h0010);

        done = 1'b1;
        report();
    end

endmodule